// File: doc/BRIEF.md
# Per-Lane Read Strobe Enable Timer

This block times the opening of the strobe receive window for each byte lane of a DDR read data path. A read command strobe, sampled on the controller clock edge that puts the read on the command bus, starts a countdown in every lane. Once the configured CAS latency plus that lane's whole-cycle offset has elapsed, the lane raises a single-cycle enable pulse. During that pulse it also presents a quarter-cycle phase select and a fine sub-quarter code, which an external delay line uses to place the window edge near the middle of the strobe preamble. An edge that is too early admits noise. An edge that is too late misses real strobe transitions.

Each lane holds one 8-bit timing code, which software writes and reads back through a small register port. The same code applies to every rank. Bits [7:5] of the code select whole cycles, bits [4:3] select the quarter phase, and bits [2:0] select the fine step. Each lane keeps a shift pipeline of in-flight reads. Reads on consecutive cycles therefore each produce their own pulse, and every read keeps the latency and code that were current when it was launched.

Top module: `rcven_delay_gen`

## Requirements
- R1: After reset, every lane code reads as 0x00, and every enable, phase and fine output is 0.
- R2: When `cfg_we` is sampled high, `cfg_wdata` is stored as the code of lane `cfg_lane`. `cfg_rdata` shows the stored code of the lane currently selected by `cfg_lane`, without delay. The other lanes keep their codes.
- R3: A read strobe sampled at clock edge k raises lane L's enable for exactly one cycle, after edge k + CLe + code[7:5]. Here CLe is the effective CAS latency and code is lane L's code.
- R4: While a lane's enable is high, its phase output equals code[4:3] and its fine output equals code[2:0]. While the enable is low, both outputs are 0.
- R5: A programmed CAS latency of 0 behaves as 1 (CLe = 1). Any other value is used as it is.
- R6: Code 0x00 gives the minimum delay, CLe, with phase 0 and fine 0. Code 0xFF gives the maximum delay, CLe + 7, with phase 3 and fine 7.
- R7: Reads on consecutive cycles, or at any spacing, each produce their own pulse at their own cycle. No pulse is lost.
- R8: A read uses the lane code and CAS latency present at the edge where it is sampled. A code write on that same edge, or on any later edge, does not affect it. A later latency change does not affect it either.
- R9: If two reads in one lane are due in the same cycle, that lane gives one pulse, carrying the phase and fine fields of the read launched later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_cmd | input | 1 | Read command issued on this edge |
| cas_lat | input | CL_W | Programmed CAS read latency in cycles |
| cfg_we | input | 1 | Write strobe for a lane code |
| cfg_lane | input | LANE_W | Lane selected for write and readback |
| cfg_wdata | input | 8 | Code to be written |
| cfg_rdata | output | 8 | Code of the selected lane |
| rcven_en | output | LANES | Per-lane one-cycle receive-enable pulse |
| rcven_phase | output | 2*LANES | Per-lane quarter-phase select, valid with the pulse |
| rcven_fine | output | 3*LANES | Per-lane sub-quarter delay code, valid with the pulse |

## Verification
Single reads are swept over every CAS latency from 0 to 15 against every whole-cycle value, with each lane holding a different offset. This separates each lane's own latency and separates the zero-latency clamp from the plain values. The extreme codes 0x00 and 0xFF fix the two ends of the range. Consecutive and spaced bursts show whether in-flight reads are kept apart or merged. Code and latency changes during a burst, including a write on the same edge as a read, show whether settings are captured at launch. A crafted pair of reads that land in the same cycle shows which read's fields win.

// File: rtl/rcven_pkg.sv
package rcven_pkg;

  localparam int COARSE_W = 3;
  localparam int PHASE_W  = 2;
  localparam int FINE_W   = 3;
  localparam int CODE_W   = COARSE_W + PHASE_W + FINE_W;

  typedef struct packed {
    logic               vld;
    logic [PHASE_W-1:0] phase;
    logic [FINE_W-1:0]  fine;
  } slot_t;

  function automatic int eff_latency(input int cl);
    return (cl == 0) ? 1 : cl;
  endfunction

  function automatic int coarse_of(input logic [CODE_W-1:0] code);
    return int'(code[CODE_W-1 -: COARSE_W]);
  endfunction

  function automatic logic [PHASE_W-1:0] phase_of(input logic [CODE_W-1:0] code);
    return code[FINE_W +: PHASE_W];
  endfunction

  function automatic logic [FINE_W-1:0] fine_of(input logic [CODE_W-1:0] code);
    return code[FINE_W-1:0];
  endfunction

  function automatic int launch_delay(input int cl, input logic [CODE_W-1:0] code);
    return eff_latency(cl) + coarse_of(code);
  endfunction

endpackage

// File: rtl/rcven_cfg_regs.sv
module rcven_cfg_regs import rcven_pkg::*; #(
  parameter int LANES  = 4,
  parameter int LANE_W = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [LANE_W-1:0]              wr_lane,
  input  logic [CODE_W-1:0]              wr_code,
  output logic [CODE_W-1:0]              sel_code,
  output logic [LANES-1:0][CODE_W-1:0]   codes
);

  logic lane_ok;
  assign lane_ok = int'(wr_lane) < LANES;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      codes <= '0;
    end else if (wr_en && lane_ok) begin
      codes[wr_lane] <= wr_code;
    end
  end

  always_comb begin
    sel_code = '0;
    if (lane_ok) sel_code = codes[wr_lane];
  end

endmodule

// File: rtl/rcven_lane_pipe.sv
module rcven_lane_pipe import rcven_pkg::*; #(
  parameter int DEPTH = 22,
  parameter int DLY_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic [DLY_W-1:0]   delay,
  input  logic [PHASE_W-1:0] phase_in,
  input  logic [FINE_W-1:0]  fine_in,
  output logic               en_out,
  output logic [PHASE_W-1:0] phase_out,
  output logic [FINE_W-1:0]  fine_out
);

  slot_t            slots [DEPTH];
  slot_t            new_slot;
  logic [DLY_W-1:0] ins_idx;

  // delay is at least one, so the slot index never wraps
  assign ins_idx  = delay - DLY_W'(1);
  assign new_slot = '{vld: 1'b1, phase: phase_in, fine: fine_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
      en_out    <= 1'b0;
      phase_out <= '0;
      fine_out  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (launch && ins_idx == DLY_W'(i)) slots[i] <= new_slot;
        else if (i == DEPTH-1)              slots[i] <= '0;
        else                                slots[i] <= slots[i+1];
      end
      en_out    <= slots[0].vld;
      phase_out <= slots[0].phase;
      fine_out  <= slots[0].fine;
    end
  end

endmodule

// File: rtl/rcven_delay_gen.sv
module rcven_delay_gen import rcven_pkg::*; #(
  parameter int LANES = 4,
  parameter int CL_W  = 4,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_cmd,
  input  logic [CL_W-1:0]           cas_lat,
  input  logic                      cfg_we,
  input  logic [LANE_W-1:0]         cfg_lane,
  input  logic [CODE_W-1:0]         cfg_wdata,
  output logic [CODE_W-1:0]         cfg_rdata,
  output logic [LANES-1:0]          rcven_en,
  output logic [LANES*PHASE_W-1:0]  rcven_phase,
  output logic [LANES*FINE_W-1:0]   rcven_fine
);

  localparam int DEPTH = ((1 << CL_W) - 1) + ((1 << COARSE_W) - 1);
  localparam int DLY_W = $clog2(DEPTH + 1);

  logic [LANES-1:0][CODE_W-1:0] lane_code;
  logic                         launch_fire;

  assign launch_fire = rd_cmd;

  rcven_cfg_regs #(.LANES(LANES), .LANE_W(LANE_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_lane  (cfg_lane),
    .wr_code  (cfg_wdata),
    .sel_code (cfg_rdata),
    .codes    (lane_code)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DLY_W-1:0] lane_delay;
    assign lane_delay = DLY_W'(launch_delay(int'(cas_lat), lane_code[g]));

    rcven_lane_pipe #(.DEPTH(DEPTH), .DLY_W(DLY_W)) u_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch_fire),
      .delay     (lane_delay),
      .phase_in  (phase_of(lane_code[g])),
      .fine_in   (fine_of(lane_code[g])),
      .en_out    (rcven_en[g]),
      .phase_out (rcven_phase[g*PHASE_W +: PHASE_W]),
      .fine_out  (rcven_fine[g*FINE_W +: FINE_W])
    );
  end

endmodule

// File: rtl/rcven_delay_chk.sv
module rcven_delay_chk import rcven_pkg::*; #(
  parameter int LANES = 4,
  parameter int CL_W  = 4,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      launch_fire,
  input logic                      cfg_we,
  input logic [LANE_W-1:0]         cfg_lane,
  input logic [CODE_W-1:0]         cfg_wdata,
  input logic [CODE_W-1:0]         cfg_rdata,
  input logic [LANES-1:0]          rcven_en,
  input logic [LANES*PHASE_W-1:0]  rcven_phase,
  input logic [LANES*FINE_W-1:0]   rcven_fine
);

  localparam int DEPTH = ((1 << CL_W) - 1) + ((1 << COARSE_W) - 1);

  logic [7:0] since_rd;
  logic       seen_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_rd <= '0;
      seen_rd  <= 1'b0;
    end else if (launch_fire) begin
      since_rd <= '0;
      seen_rd  <= 1'b1;
    end else if (since_rd != 8'hFF) begin
      since_rd <= since_rd + 8'd1;
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rcven_en == '0));

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_lane != $past(cfg_lane)) || (cfg_rdata == $past(cfg_wdata)));

  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> (cfg_lane != $past(cfg_lane)) || $stable(cfg_rdata));

  a_r3_pulse_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    (rcven_en != '0) |-> (seen_rd && int'(since_rd) <= DEPTH));

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    a_r4_idle_fields_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rcven_en[l] |-> (rcven_phase[l*PHASE_W +: PHASE_W] == '0 &&
                        rcven_fine[l*FINE_W +: FINE_W] == '0));
  end

endmodule

bind rcven_delay_gen rcven_delay_chk #(.LANES(LANES), .CL_W(CL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .launch_fire (launch_fire),
  .cfg_we      (cfg_we),
  .cfg_lane    (cfg_lane),
  .cfg_wdata   (cfg_wdata),
  .cfg_rdata   (cfg_rdata),
  .rcven_en    (rcven_en),
  .rcven_phase (rcven_phase),
  .rcven_fine  (rcven_fine)
);

// File: tb/test_rcven_delay_gen.sv
`timescale 1ns/1ps
module test_rcven_delay_gen;

  localparam int LANES = 4;
  localparam int CL_W  = 4;
  localparam int LW    = 2;
  localparam int RING  = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rd_cmd = 1'b0;
  logic [CL_W-1:0]   cas_lat = '0;
  logic              cfg_we = 1'b0;
  logic [LW-1:0]     cfg_lane = '0;
  logic [7:0]        cfg_wdata = '0;
  logic [7:0]        cfg_rdata;
  logic [LANES-1:0]  rcven_en;
  logic [LANES*2-1:0] rcven_phase;
  logic [LANES*3-1:0] rcven_fine;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string tag = "R1";
  logic [7:0] mcode [LANES];
  logic       ev [LANES][RING];
  logic [1:0] eph [LANES][RING];
  logic [2:0] efn [LANES][RING];

  always #2.5 clk = ~clk;

  rcven_delay_gen #(.LANES(LANES), .CL_W(CL_W)) i_rcven_delay_gen (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .cas_lat(cas_lat),
    .cfg_we(cfg_we), .cfg_lane(cfg_lane), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .rcven_en(rcven_en),
    .rcven_phase(rcven_phase), .rcven_fine(rcven_fine)
  );

  function automatic int model_delay(input int cl, input logic [7:0] code);
    int base;
    base = cl;
    if (base < 1) base = 1;
    return base + (code / 32);
  endfunction

  task automatic tick(input logic rd, input logic we, input int lane, input logic [7:0] wd);
    rd_cmd = rd; cfg_we = we; cfg_lane = LW'(lane); cfg_wdata = wd;
    if (rd) begin
      for (int l = 0; l < LANES; l++) begin
        int slot;
        slot = (cyc + 1 + model_delay(int'(cas_lat), mcode[l])) % RING;
        ev[l][slot]  = 1'b1;
        eph[l][slot] = 2'((mcode[l] / 8) % 4);
        efn[l][slot] = 3'(mcode[l] % 8);
      end
    end
    if (we) mcode[lane] = wd;
    @(posedge clk);
    cyc++;
    @(negedge clk);
    rd_cmd = 1'b0; cfg_we = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      int s;
      s = cyc % RING;
      checks++;
      if (rcven_en[l] !== ev[l][s] || rcven_phase[l*2 +: 2] !== eph[l][s] ||
          rcven_fine[l*3 +: 3] !== efn[l][s]) begin
        errors++;
        $display("FAIL %s lane %0d cyc %0d: got en=%b ph=%0d fn=%0d expected en=%b ph=%0d fn=%0d",
                 tag, l, cyc, rcven_en[l], rcven_phase[l*2 +: 2], rcven_fine[l*3 +: 3],
                 ev[l][s], eph[l][s], efn[l][s]);
      end
      ev[l][s] = 1'b0; eph[l][s] = '0; efn[l][s] = '0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 0, 8'h00);
  endtask

  task automatic check_rd(input int lane, input logic [7:0] exp);
    cfg_lane = LW'(lane);
    #0.5;
    checks++;
    if (cfg_rdata !== exp) begin
      errors++;
      $display("FAIL %s readback lane %0d: got %02h expected %02h", tag, lane, cfg_rdata, exp);
    end
  endtask

  task automatic set_codes(input logic [7:0] c0, input logic [7:0] c1,
                           input logic [7:0] c2, input logic [7:0] c3);
    tick(1'b0, 1'b1, 0, c0);
    tick(1'b0, 1'b1, 1, c1);
    tick(1'b0, 1'b1, 2, c2);
    tick(1'b0, 1'b1, 3, c3);
  endtask

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int l = 0; l < LANES; l++) begin
      mcode[l] = 8'h00;
      for (int s = 0; s < RING; s++) begin ev[l][s] = 1'b0; eph[l][s] = '0; efn[l][s] = '0; end
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state at the ports
    tag = "R1";
    checks++;
    if (rcven_en !== '0 || rcven_phase !== '0 || rcven_fine !== '0) begin
      errors++;
      $display("FAIL R1 outputs in reset: got en=%b ph=%h fn=%h expected 0", rcven_en, rcven_phase, rcven_fine);
    end
    rst_n = 1'b1;
    for (int l = 0; l < LANES; l++) check_rd(l, 8'h00);
    idle(2);

    // R2: write each lane, read all back
    tag = "R2";
    set_codes(8'h5A, 8'hC3, 8'h17, 8'hE8);
    check_rd(0, 8'h5A); check_rd(1, 8'hC3); check_rd(2, 8'h17); check_rd(3, 8'hE8);
    tick(1'b0, 1'b1, 2, 8'h99);
    check_rd(0, 8'h5A); check_rd(1, 8'hC3); check_rd(2, 8'h99); check_rd(3, 8'hE8);

    // R3/R4/R5 sweep: every latency against every whole-cycle value
    for (int cl = 0; cl < 16; cl++) begin
      for (int c = 0; c < 8; c++) begin
        tag = (cl == 0) ? "R5" : "R3";
        cas_lat = CL_W'(cl);
        set_codes(8'({3'((c+0)%8), 2'((cl+0)%4), 3'((c+1)%8)}),
                  8'({3'((c+1)%8), 2'((cl+1)%4), 3'((c+3)%8)}),
                  8'({3'((c+2)%8), 2'((cl+2)%4), 3'((c+5)%8)}),
                  8'({3'((c+5)%8), 2'((cl+3)%4), 3'((c+7)%8)}));
        tick(1'b1, 1'b0, 0, 8'h00);
        tag = "R4";
        idle(24);
      end
    end

    // R6: range ends
    tag = "R6";
    cas_lat = 4'd3;
    set_codes(8'h00, 8'hFF, 8'h00, 8'hFF);
    tick(1'b1, 1'b0, 0, 8'h00);
    idle(24);
    cas_lat = 4'd15;
    tick(1'b1, 1'b0, 0, 8'h00);
    idle(24);

    // R7: consecutive and spaced reads
    tag = "R7";
    cas_lat = 4'd2;
    set_codes(8'h00, 8'h2B, 8'h74, 8'hE1);
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, 0, 8'h00);
    for (int i = 0; i < 4; i++) begin tick(1'b1, 1'b0, 0, 8'h00); tick(1'b0, 1'b0, 0, 8'h00); end
    idle(24);

    // R8: settings captured at launch; same-edge write does not affect the read
    tag = "R8";
    cas_lat = 4'd4;
    set_codes(8'h6D, 8'h20, 8'hA2, 8'h4F);
    tick(1'b1, 1'b1, 0, 8'h09);
    tick(1'b0, 1'b1, 1, 8'hF6);
    cas_lat = 4'd1;
    tick(1'b1, 1'b1, 3, 8'h00);
    cas_lat = 4'd7;
    tick(1'b1, 1'b0, 0, 8'h00);
    idle(24);

    // R9: two reads landing together in lane 0
    tag = "R9";
    cas_lat = 4'd3;
    set_codes(8'hE5, 8'h40, 8'h40, 8'h40);
    tick(1'b1, 1'b1, 0, 8'hDA);
    tick(1'b1, 1'b0, 0, 8'h00);
    idle(24);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule